// File: doc/BRIEF.md
# Battery charge mode controller

This block decides, cycle by cycle, whether a battery charger runs in fast-charge or trickle-charge mode. Every input is an already-digitized status flag: pack voltage inside the fast-charge window, a sample strobe with its negative delta-V result, a holdoff-active flag from the charge timer, timer expiry, temperature below the cold limit, temperature above the hot limit, supply in range, and undervoltage lockout. Analog comparison, voltage sampling and the delta-V measurement all live outside the block.

Three terminating conditions drive the charger into a latched trickle state: a full-charge detection (consecutive negative delta-V samples), timer expiry and over-temperature. Only a reset pulse can clear that latch. The block generates this pulse itself when the pack voltage enters the window or when the supply comes back into range. The same output is held high during undervoltage lockout, so that the timer and the over-temperature latch stay cleared. Two other conditions give trickle mode without latching: voltage outside the window and a cold pack. These end as soon as the condition goes away.

Top module: `chg_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after it is released with all flags low, `fast_o` and `tmr_rst_o` are both 0.
- R2: When `win_ok_i` is sampled high after having been low on the previous edge, `tmr_rst_o` is 1 for exactly the following cycle. If no latch is set and the other conditions allow it, `fast_o` becomes 1 after that same edge.
- R3: When `win_ok_i` is low, `fast_o` is 0 after the next edge. This trickle is not latched: once the window is entered again, `fast_o` returns to 1 after the next edge.
- R4: When `fast_o` is 1, `holdoff_i` is low and a `dv_smp_i` strobe with `dv_evt_i` high is the second in a row, `fast_o` goes to 0 after that edge and stays 0 until a reset pulse has been produced.
- R5: A `dv_smp_i` strobe with `dv_evt_i` low sets the run of consecutive events back to zero. While `holdoff_i` is high the run is held at zero, so events in holdoff never count.
- R6: When `tmr_exp_i` is high while `fast_o` is 1, the block enters latched trickle (`fast_o` 0 after that edge).
- R7: While `temp_low_i` is high, `fast_o` is 0. When it falls, `fast_o` returns to 1 after the next edge, with no reset pulse needed.
- R8: When `temp_high_i` is high, the latch is set in any mode. A reset pulse issued while `temp_high_i` is still high does not clear it. A pulse issued after `temp_high_i` has fallen does clear it.
- R9: A rising edge on `vcc_ok_i` produces a one-cycle `tmr_rst_o` pulse, which clears a latched trickle state.
- R10: While `uvlo_i` is high, `fast_o` is 0 and `tmr_rst_o` is held at 1 (one cycle of latency), and the latch is cleared.
- R11: `fast_o` is 1 after an edge only if `win_ok_i`, `vcc_ok_i`, not `uvlo_i` and not `temp_low_i` all held on that edge and no latch was left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_ok_i | input | 1 | Pack voltage inside the fast-charge window |
| dv_smp_i | input | 1 | Delta-V sample strobe, one cycle per sample |
| dv_evt_i | input | 1 | Negative delta-V seen on this sample (valid with strobe) |
| holdoff_i | input | 1 | Initial holdoff period active |
| tmr_exp_i | input | 1 | Charge timer expired |
| temp_low_i | input | 1 | Pack colder than lower limit |
| temp_high_i | input | 1 | Pack hotter than upper limit |
| vcc_ok_i | input | 1 | Supply above the upper undervoltage threshold |
| uvlo_i | input | 1 | Undervoltage lockout active |
| fast_o | output | 1 | 1 = fast charge, 0 = trickle (registered) |
| tmr_rst_o | output | 1 | Reset to charge timer and over-temperature latch |

## Verification
The bench drives delta-V patterns that are broken by an event-free sample, and events that fall inside holdoff. A counter that does not clear would terminate the charge too early on these. Over-temperature is asserted across a window re-entry, because a latch that clears on any pulse would resume fast charge while the pack is still hot. Each terminating cause is released and the block is re-armed through both pulse sources: a latch that never clears would leave the charger stuck in trickle, and one that is not latched at all would return to fast charge by itself. A sweep over all sixteen combinations of window, supply, lockout and cold flags compares the mode and reset outputs against the enable equation.

// File: rtl/chg_mode_pkg.sv
package chg_mode_pkg;
  typedef enum logic {
    MODE_TRICKLE = 1'b0,
    MODE_FAST    = 1'b1
  } mode_e;
endpackage

// File: rtl/chg_rise_det.sv
module chg_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/chg_dv_run.sv
module chg_dv_run #(
  parameter int unsigned DV_NEED = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic holdoff_i,
  input  logic smp_i,
  input  logic evt_i,
  output logic done_o
);
  localparam int unsigned CNT_W = (DV_NEED > 1) ? $clog2(DV_NEED) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DV_NEED - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             live;

  assign live   = en_i & ~holdoff_i;
  assign done_o = live & smp_i & evt_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!live)           cnt_q <= '0;
    else if (smp_i) begin
      if (!evt_i || cnt_q == LAST) cnt_q <= '0;
      else                         cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/chg_mode_fsm.sv
module chg_mode_fsm
  import chg_mode_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic win_ok_i,
  input  logic vcc_ok_i,
  input  logic uvlo_i,
  input  logic temp_low_i,
  input  logic temp_high_i,
  input  logic tmr_exp_i,
  input  logic dv_done_i,
  input  logic rst_req_i,
  output logic fast_o,
  output logic tmr_rst_o
);
  mode_e mode_q, mode_d;
  logic  latch_q, latch_d, allow, term_set;

  assign fast_o = (mode_q == MODE_FAST);

  // termination while fast; over-temperature in any mode
  assign term_set = temp_high_i | (fast_o & (tmr_exp_i | dv_done_i));

  always_comb begin
    latch_d = latch_q;
    if (tmr_rst_o) latch_d = 1'b0;
    if (term_set)  latch_d = 1'b1;
  end

  assign allow  = win_ok_i & vcc_ok_i & ~uvlo_i & ~temp_low_i & ~latch_d;
  assign mode_d = allow ? MODE_FAST : MODE_TRICKLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_TRICKLE;
      latch_q   <= 1'b0;
      tmr_rst_o <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      latch_q   <= latch_d;
      tmr_rst_o <= rst_req_i | uvlo_i;
    end
  end
endmodule

// File: rtl/chg_mode_ctrl.sv
module chg_mode_ctrl #(
  parameter int unsigned DV_NEED = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic win_ok_i,
  input  logic dv_smp_i,
  input  logic dv_evt_i,
  input  logic holdoff_i,
  input  logic tmr_exp_i,
  input  logic temp_low_i,
  input  logic temp_high_i,
  input  logic vcc_ok_i,
  input  logic uvlo_i,
  output logic fast_o,
  output logic tmr_rst_o
);
  localparam int unsigned N_EDGE = 2;

  logic [N_EDGE-1:0] lvl, rise;
  logic              dv_done;

  assign lvl = {vcc_ok_i, win_ok_i};

  for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
    chg_rise_det u_rise (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (lvl[g]),
      .rise_o (rise[g])
    );
  end

  chg_dv_run #(.DV_NEED(DV_NEED)) u_dv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (fast_o),
    .holdoff_i (holdoff_i),
    .smp_i     (dv_smp_i),
    .evt_i     (dv_evt_i),
    .done_o    (dv_done)
  );

  chg_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_ok_i    (win_ok_i),
    .vcc_ok_i    (vcc_ok_i),
    .uvlo_i      (uvlo_i),
    .temp_low_i  (temp_low_i),
    .temp_high_i (temp_high_i),
    .tmr_exp_i   (tmr_exp_i),
    .dv_done_i   (dv_done),
    .rst_req_i   (|rise),
    .fast_o      (fast_o),
    .tmr_rst_o   (tmr_rst_o)
  );
endmodule

// File: rtl/chg_mode_ctrl_chk.sv
module chg_mode_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic win_ok_i,
  input logic tmr_exp_i,
  input logic temp_low_i,
  input logic temp_high_i,
  input logic vcc_ok_i,
  input logic uvlo_i,
  input logic fast_o,
  input logic tmr_rst_o
);
  assert_win_rise_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_ok_i) |=> tmr_rst_o);
  assert_out_of_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_ok_i |=> !fast_o);
  assert_timer_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_o && tmr_exp_i) |=> !fast_o);
  assert_cold_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_low_i |=> !fast_o);
  assert_hot_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_high_i |=> !fast_o);
  assert_vcc_rise_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vcc_ok_i) |=> tmr_rst_o);
  assert_uvlo_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> (tmr_rst_o && !fast_o));
  assert_enable_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(win_ok_i && vcc_ok_i && !uvlo_i && !temp_low_i) |=> !fast_o);
endmodule

bind chg_mode_ctrl chg_mode_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .win_ok_i    (win_ok_i),
  .tmr_exp_i   (tmr_exp_i),
  .temp_low_i  (temp_low_i),
  .temp_high_i (temp_high_i),
  .vcc_ok_i    (vcc_ok_i),
  .uvlo_i      (uvlo_i),
  .fast_o      (fast_o),
  .tmr_rst_o   (tmr_rst_o)
);

// File: tb/chg_mode_ctrl_tb.sv
module chg_mode_ctrl_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic win_ok_i = 0, dv_smp_i = 0, dv_evt_i = 0, holdoff_i = 0, tmr_exp_i = 0;
  logic temp_low_i = 0, temp_high_i = 0, vcc_ok_i = 0, uvlo_i = 0;
  logic fast_o, tmr_rst_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  chg_mode_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .win_ok_i(win_ok_i), .dv_smp_i(dv_smp_i),
    .dv_evt_i(dv_evt_i), .holdoff_i(holdoff_i), .tmr_exp_i(tmr_exp_i),
    .temp_low_i(temp_low_i), .temp_high_i(temp_high_i), .vcc_ok_i(vcc_ok_i),
    .uvlo_i(uvlo_i), .fast_o(fast_o), .tmr_rst_o(tmr_rst_o)
  );

  task automatic chk(string req, logic exp_fast, logic exp_rst);
    n_chk++;
    if (fast_o !== exp_fast || tmr_rst_o !== exp_rst) begin
      n_fail++;
      $display("FAIL %s: fast=%b rst=%b expected fast=%b rst=%b",
               req, fast_o, tmr_rst_o, exp_fast, exp_rst);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic dv_sample(logic evt);
    dv_smp_i = 1; dv_evt_i = evt;
    tick();
    dv_smp_i = 0; dv_evt_i = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    tick(2);
    rst_ni = 1;
  endtask

  initial begin
    tick(2);
    chk("R1 in reset", 0, 0);
    rst_ni = 1;
    tick();
    chk("R1 after release", 0, 0);

    vcc_ok_i = 1; tick();
    chk("R9 vcc rise pulse", 0, 1);
    tick();
    chk("R9 pulse one cycle", 0, 0);

    win_ok_i = 1; tick();
    chk("R2 window entry", 1, 1);
    tick();
    chk("R2 pulse ends", 1, 0);

    holdoff_i = 1;
    dv_sample(1); dv_sample(1); dv_sample(1);
    tick();
    chk("R5 holdoff events ignored", 1, 0);
    holdoff_i = 0;
    dv_sample(1); dv_sample(0); dv_sample(1);
    tick();
    chk("R5 broken run", 1, 0);
    dv_sample(1);
    chk("R4 second consecutive event", 0, 0);
    tick(4);
    chk("R4 latched in window", 0, 0);
    win_ok_i = 0; tick();
    win_ok_i = 1; tick();
    chk("R4 pulse, latch still set", 0, 1);
    tick();
    chk("R4 cleared by pulse", 1, 0);

    win_ok_i = 0; tick();
    chk("R3 window left", 0, 0);
    win_ok_i = 1; tick();
    chk("R3 re-entry", 1, 1);
    tick();

    tmr_exp_i = 1; tick();
    tmr_exp_i = 0;
    chk("R6 timer expiry", 0, 0);
    tick(3);
    chk("R6 latched", 0, 0);
    vcc_ok_i = 0; tick();
    vcc_ok_i = 1; tick();
    chk("R9 pulse on supply recovery", 0, 1);
    tick();
    chk("R9 latch cleared", 1, 0);

    temp_low_i = 1; tick();
    chk("R7 cold", 0, 0);
    tick(3);
    chk("R7 cold hold", 0, 0);
    temp_low_i = 0; tick();
    chk("R7 warm again", 1, 0);

    temp_high_i = 1; tick();
    chk("R8 hot", 0, 0);
    win_ok_i = 0; tick();
    win_ok_i = 1; tick();
    chk("R8 pulse while hot", 0, 1);
    tick();
    chk("R8 still latched", 0, 0);
    temp_high_i = 0; tick(3);
    chk("R8 latched after cooling", 0, 0);
    win_ok_i = 0; tick();
    win_ok_i = 1; tick(2);
    chk("R8 released", 1, 0);

    uvlo_i = 1; tick();
    chk("R10 lockout", 0, 1);
    tick(3);
    chk("R10 lockout hold", 0, 1);
    uvlo_i = 0; tick();
    chk("R10 lockout release", 1, 0);

    for (int c = 0; c < 16; c++) begin
      win_ok_i = 0; vcc_ok_i = 0; uvlo_i = 0; temp_low_i = 0;
      do_reset();
      win_ok_i = c[0]; vcc_ok_i = c[1]; uvlo_i = c[2]; temp_low_i = c[3];
      tick(3);
      chk("R11 enable sweep", c[0] & c[1] & ~c[2] & ~c[3], c[2]);
    end

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: done=0 expected done=1");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule